// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Queue and Empty Flags

This block turns bytes written by a host into asynchronous serial frames on a single line. Each frame is a low start bit, 5 to 8 data bits with bit 0 first, an optional parity bit and one or two high stop bits. Bit timing comes from an external enable pulse that runs at sixteen times the baud rate.

Host writes land either in a single holding slot or, in queued mode, in a 128-entry first-in first-out store. The shifter pulls the next byte from that store on its own. Two flags tell the host how far the transmitter has drained: one for the holding slot or queue, and one for the whole path including the shifter. A maskable interrupt flags that there is room for more data. In queued mode it is raised in two stages: first when the fill level drops below a programmable mark, and again when the queue runs dry.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, tx_out is 1, thr_empty is 1, tx_empty is 1 and irq is 0.
- R2: A frame is one low start bit, then the data bits with bit 0 first, then high stop bits. The line stays high between frames.
- R3: data_sel values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, taken from the low bits of wr_data. stop_two=1 sends two stop bits and stop_two=0 sends one. These settings are captured when a byte enters the shifter.
- R4: Every bit, the start bit included, lasts exactly 16 baud_tick pulses. tx_out does not change in a cycle without a tick unless a new frame starts.
- R5: With parity_en=1, one parity bit follows the data bits. It is computed over the data bits only. With parity_odd=0 the data bits plus the parity bit hold an even number of ones, and with parity_odd=1 an odd number.
- R6: With fifo_mode=0, a write makes thr_empty 0 on the next cycle. thr_empty returns to 1 one cycle later if the shifter is idle, because the byte has moved into the shifter. A write while the holding slot is occupied is ignored.
- R7: With fifo_mode=1, up to DEPTH bytes queue behind the shifter and are sent in write order. A write while the queue is full is ignored.
- R8: tx_empty is 1 only when the holding slot or queue is empty and no frame is being shifted.
- R9: With fifo_mode=1 and trig_level greater than 0, the transmit interrupt becomes pending when the fill level drops from trig_level to trig_level-1. A level that stays at or above trig_level raises nothing.
- R10: In either mode, the transmit interrupt becomes pending when the holding slot or queue goes from non-empty to empty.
- R11: A write strobe or an isr_rd strobe clears a pending interrupt, unless a new interrupt event occurs in the same cycle, which wins. irq equals pending AND irq_en.
- R12: A pulse on fifo_clear empties the queue at once. A frame already in the shifter completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse at 16x baud rate |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1 = 128-entry queue, 0 = single holding slot |
| fifo_clear | input | 1 | Empties the queue |
| data_sel | input | 2 | Data bit count minus 5 |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits |
| irq_en | input | 1 | Transmit interrupt enable |
| trig_level | input | CNT_W | Fill level for the first interrupt stage |
| isr_rd | input | 1 | Interrupt-status read strobe, clears pending |
| tx_out | output | 1 | Serial line |
| thr_empty | output | 1 | Holding slot or queue empty |
| tx_empty | output | 1 | Holding slot, queue and shifter all empty |
| irq | output | 1 | Transmit interrupt |

## Verification
A wrong occupancy count shows at the ports within one frame. A missing or extra byte appears on the line, and the two empty flags change in the wrong cycle. The interrupt line then drops or rises one frame early or late around the trigger mark. A shifter that miscounts ticks or bits shifts a sample edge or a stop bit by at least one bit period, so the decoded byte or its parity is wrong in that very frame. Because the interrupt is checked one frame at a time around its two events, an off-by-one in the crossing test shows up one frame early or late.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FRAME_W = 12;

  // Number of data bits selected by the 2-bit length field.
  function automatic int data_len(input logic [1:0] sel);
    return 5 + int'(sel);
  endfunction

  // Parity over the selected data bits; odd_sel inverts the even result.
  function automatic logic calc_parity(input logic [7:0] d, input logic [1:0] sel,
                                       input logic odd_sel);
    logic p;
    p = odd_sel;
    for (int i = 0; i < 8; i++)
      if (i < data_len(sel)) p = p ^ d[i];
    return p;
  endfunction

  // Total bits on the line for one frame.
  function automatic logic [3:0] frame_len(input logic [1:0] sel, input logic pen,
                                           input logic two);
    return 4'(2 + data_len(sel) + int'(pen) + int'(two));
  endfunction

  // Frame image, element 0 leaves first; unused tail stays high.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
      input logic [1:0] sel, input logic pen, input logic odd_sel);
    logic [FRAME_W-1:0] v;
    int nd;
    nd = data_len(sel);
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nd) v[i+1] = d[i];
    if (pen) v[nd+1] = calc_parity(d, sel, odd_sel);
    return v;
  endfunction

  // Interrupt event: store drained to empty, or queued level crossed below mark.
  function automatic logic tx_irq_event(input int unsigned was, input int unsigned nxt,
                                        input int unsigned mark, input logic queued);
    logic drained, crossed;
    drained = (was != 0) && (nxt == 0);
    crossed = queued && (mark != 0) && (was >= mark) && (nxt < mark);
    return drained || crossed;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             queued,
  input  logic             push_req,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head_data,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             empty
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push;

  // In single-slot mode the store is treated as one entry deep.
  assign full  = queued ? (count_q == CNT_W'(DEPTH)) : (count_q != '0);
  assign empty = (count_q == '0);
  assign push  = push_req && !full && !clear;
  assign head_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clear) count_nxt = '0;
    else       count_nxt = count_q + CNT_W'(push) - CNT_W'(pop && !empty);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      count_q <= count_nxt;
      if (clear) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= ptr_inc(wr_ptr);
        if (pop && !empty) rd_ptr <= ptr_inc(rd_ptr);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R7
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_req && !pop && !clear |=> $stable(count_q)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty); // R12

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int TICKS = 16,
  localparam int TICK_W = $clog2(TICKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic [1:0] data_sel,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       stop_two,
  output logic       tx_out,
  output logic       busy,
  output logic       frame_end
);

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bits_left;
  logic [TICK_W-1:0]  tick_q;
  logic               bit_end;

  assign bit_end   = busy && baud_tick && (tick_q == TICK_W'(TICKS - 1));
  assign frame_end = bit_end && (bits_left == '0);
  assign tx_out    = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      tick_q    <= '0;
      busy      <= 1'b0;
    end else if (load) begin
      shreg     <= build_frame(load_data, data_sel, parity_en, parity_odd);
      bits_left <= frame_len(data_sel, parity_en, stop_two) - 4'd1;
      tick_q    <= '0;
      busy      <= 1'b1;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tick_q <= '0;
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        if (bits_left == '0) busy <= 1'b0;
        else                 bits_left <= bits_left - 4'd1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && !tx_out); // R2
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick && !load |=> $stable(tx_out)); // R4

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queued,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic [CNT_W-1:0] trig_level,
  input  logic             wr_en,
  input  logic             isr_rd,
  input  logic             irq_en,
  output logic             pending,
  output logic             irq
);

  logic fire;

  assign fire = tx_irq_event(32'(count_q), 32'(count_nxt), 32'(trig_level), queued);
  assign irq  = pending && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pending <= 1'b0;
    else if (fire)              pending <= 1'b1;
    else if (wr_en || isr_rd)   pending <= 1'b0;
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pending); // R10
  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || isr_rd) && !fire |=> !pending); // R11

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int DEPTH = 128,
  parameter int TICKS = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             fifo_mode,
  input  logic             fifo_clear,
  input  logic [1:0]       data_sel,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             stop_two,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] trig_level,
  input  logic             isr_rd,
  output logic             tx_out,
  output logic             thr_empty,
  output logic             tx_empty,
  output logic             irq
);

  logic [7:0]       head_data;
  logic [CNT_W-1:0] count_q, count_nxt;
  logic             full, empty, busy, frame_end, load, pending;

  // Reload on the same edge the last stop bit ends, so frames run back to back.
  assign load      = !empty && (!busy || frame_end);
  assign thr_empty = empty;
  assign tx_empty  = empty && !busy;

  uart_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .queued(fifo_mode),
    .push_req(wr_en), .push_data(wr_data), .pop(load), .head_data(head_data),
    .count_q(count_q), .count_nxt(count_nxt), .full(full), .empty(empty)
  );

  uart_tx_shifter #(.TICKS(TICKS)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
    .load_data(head_data), .data_sel(data_sel), .parity_en(parity_en),
    .parity_odd(parity_odd), .stop_two(stop_two), .tx_out(tx_out),
    .busy(busy), .frame_end(frame_end)
  );

  uart_tx_irq #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .queued(fifo_mode), .count_q(count_q),
    .count_nxt(count_nxt), .trig_level(trig_level), .wr_en(wr_en),
    .isr_rd(isr_rd), .irq_en(irq_en), .pending(pending), .irq(irq)
  );

  AST_TX_EMPTY_NEEDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty); // R8
  AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_empty); // R8
  AST_FULL_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty); // R7

endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, baud_tick = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fifo_mode = 1'b0, fifo_clear = 1'b0;
  logic [1:0] data_sel = 2'd3;
  logic       parity_en = 1'b0, parity_odd = 1'b0, stop_two = 1'b0;
  logic       irq_en = 1'b0, isr_rd = 1'b0;
  logic [7:0] trig_level = 8'd0;
  logic       tx_out, thr_empty, tx_empty, irq;

  int checks = 0, errors = 0;
  int tick_div = 1, tick_cnt = 0;
  bit finished = 0;

  uart_tx_core i_uart_tx_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .fifo_clear(fifo_clear), .data_sel(data_sel),
    .parity_en(parity_en), .parity_odd(parity_odd), .stop_two(stop_two),
    .irq_en(irq_en), .trig_level(trig_level), .isr_rd(isr_rd), .tx_out(tx_out),
    .thr_empty(thr_empty), .tx_empty(tx_empty), .irq(irq)
  );

  always @(negedge clk) begin
    if (tick_cnt + 1 >= tick_div) begin tick_cnt = 0; baud_tick = 1'b1; end
    else begin tick_cnt = tick_cnt + 1; baud_tick = 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic burst(input logic [7:0] base, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = base + 8'(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic pulse_isr();
    @(negedge clk); isr_rd = 1'b1;
    @(negedge clk); isr_rd = 1'b0;
  endtask

  // Line decoder: samples mid-bit, returns data, parity bit and framing status.
  task automatic rx_frame(input int nd, input bit pen, input int stops, input int per,
                          output logic [7:0] d, output logic pb, output bit ok);
    int waited = 0;
    d = '0; pb = 1'b0; ok = 1;
    while (tx_out !== 1'b0 && waited < 30000) begin @(negedge clk); waited++; end
    if (waited >= 30000) begin ok = 0; return; end
    repeat (per / 2 - 1) @(negedge clk);
    if (tx_out !== 1'b0) ok = 0;
    for (int i = 0; i < nd; i++) begin repeat (per) @(negedge clk); d[i] = tx_out; end
    if (pen) begin repeat (per) @(negedge clk); pb = tx_out; end
    for (int s = 0; s < stops; s++) begin
      repeat (per) @(negedge clk);
      if (tx_out !== 1'b1) ok = 0;
    end
    repeat (per / 2 + 1) @(negedge clk);
  endtask

  task automatic watch_idle(input int n, input string req);
    bit bad = 0;
    repeat (n) begin @(negedge clk); if (tx_out !== 1'b1) bad = 1; end
    chk(!bad && tx_empty === 1'b1 && thr_empty === 1'b1, req, "line idle and empty",
        {tx_out, tx_empty, thr_empty}, 3'b111);
  endtask

  task automatic set_fmt(input logic [1:0] sel, input logic pen, input logic odd,
                         input logic two);
    @(negedge clk); data_sel = sel; parity_en = pen; parity_odd = odd; stop_two = two;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_out === 1'b1 && thr_empty === 1'b1 && tx_empty === 1'b1 && irq === 1'b0,
        "R1", "reset state", {tx_out, thr_empty, tx_empty, irq}, 4'b1110);
  endtask

  task automatic t_frame_8n1();
    logic [7:0] d; logic pb; bit ok;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
    fork
      wr(8'hA5);
      rx_frame(8, 0, 1, 16, d, pb, ok);
    join
    chk(ok, "R2", "8N1 framing", int'(ok), 1);
    chk(d == 8'hA5, "R2", "8N1 data LSB first", d, 8'hA5);
  endtask

  task automatic t_formats();
    logic [7:0] vals [3] = '{8'h35, 8'h13, 8'h2C};
    int lens [3] = '{7, 5, 6};
    bit odds [3] = '{0, 1, 1};
    int stp [3] = '{1, 2, 1};
    for (int k = 0; k < 3; k++) begin
      logic [7:0] d, mask; logic pb; bit ok; int ones;
      set_fmt(2'(lens[k] - 5), 1'b1, odds[k], stp[k] == 2);
      fork
        wr(vals[k] | 8'hC0);
        rx_frame(lens[k], 1, stp[k], 16, d, pb, ok);
      join
      mask = 8'((1 << lens[k]) - 1);
      chk(ok, "R3", "length/stop framing", int'(ok), 1);
      chk(d == ((vals[k] | 8'hC0) & mask), "R3", "data bits", d, (vals[k] | 8'hC0) & mask);
      ones = int'(pb);
      for (int i = 0; i < lens[k]; i++) ones += int'(d[i]);
      chk((ones % 2) == int'(odds[k]), "R5", "parity sense", ones % 2, int'(odds[k]));
    end
  endtask

  task automatic t_bit_time();
    logic [7:0] d; logic pb; bit ok; int n = 0;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
    fork
      wr(8'h01);
      begin
        while (tx_out !== 1'b0) @(negedge clk);
        do begin @(negedge clk); n++; end while (tx_out === 1'b0 && n < 100);
      end
    join
    chk(n == 16, "R4", "start bit length in ticks", n, 16);
    while (tx_empty !== 1'b1) @(negedge clk);
    tick_div = 2;
    fork
      wr(8'hC3);
      rx_frame(8, 0, 1, 32, d, pb, ok);
    join
    chk(ok && d == 8'hC3, "R4", "frame at half tick rate", d, 8'hC3);
    while (tx_empty !== 1'b1) @(negedge clk);
    tick_div = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_single_slot();
    logic [7:0] d1, d2; logic pb; bit ok1, ok2;
    set_fmt(2'd3, 1'b0, 1'b0, 1'b0);
    fifo_mode = 1'b0;
    fork
      begin
        wr(8'h11);
        chk(thr_empty === 1'b0, "R6", "flag low after write", thr_empty, 0);
        @(negedge clk);
        chk(thr_empty === 1'b1 && tx_empty === 1'b0, "R6", "moved to shifter",
            {thr_empty, tx_empty}, 2'b10);
        wr(8'h22);
        chk(thr_empty === 1'b0, "R6", "slot occupied", thr_empty, 0);
        wr(8'h33);
      end
      begin
        rx_frame(8, 0, 1, 16, d1, pb, ok1);
        chk(thr_empty === 1'b1 && tx_empty === 1'b0, "R8", "slot empty, shifter busy",
            {thr_empty, tx_empty}, 2'b10);
        rx_frame(8, 0, 1, 16, d2, pb, ok2);
      end
    join
    chk(ok1 && d1 == 8'h11, "R6", "first byte", d1, 8'h11);
    chk(ok2 && d2 == 8'h22, "R6", "second byte", d2, 8'h22);
    watch_idle(200, "R6");
  endtask

  task automatic t_queue_full();
    logic [7:0] got [129]; bit oks [129];
    fifo_mode = 1'b1;
    fork
      begin
        wr(8'h00);
        burst(8'h01, 128);
        burst(8'hEE, 2);
        chk(thr_empty === 1'b0, "R7", "queue holds data", thr_empty, 0);
      end
      for (int k = 0; k < 129; k++) begin
        logic pb;
        rx_frame(8, 0, 1, 16, got[k], pb, oks[k]);
      end
    join
    for (int k = 0; k < 129; k++)
      chk(oks[k] && got[k] == 8'(k), "R7", "queued byte order", got[k], k);
    watch_idle(200, "R7");
  endtask

  task automatic t_irq_stages();
    fifo_mode = 1'b1; trig_level = 8'd4; irq_en = 1'b1;
    pulse_isr();
    chk(irq === 1'b0, "R11", "read strobe clears", irq, 0);
    fork
      begin
        burst(8'h40, 6);
        chk(irq === 1'b0, "R11", "write clears pending", irq, 0);
      end
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d; logic pb; bit ok;
        rx_frame(8, 0, 1, 16, d, pb, ok);
        chk(ok && d == 8'h40 + 8'(k), "R7", "irq test data", d, 8'h40 + k);
        if (k == 0) chk(irq === 1'b0, "R9", "level 5 to 4 silent", irq, 0);
        if (k == 1) begin
          chk(irq === 1'b1, "R9", "level 4 to 3 raises", irq, 1);
          pulse_isr();
          chk(irq === 1'b0, "R11", "read strobe clears", irq, 0);
        end
        if (k == 3) chk(irq === 1'b0, "R9", "2 to 1 silent", irq, 0);
        if (k == 4) chk(irq === 1'b1, "R10", "drained raises", irq, 1);
      end
    join
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R11", "masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R11", "unmasked pending", irq, 1);
    fork
      begin
        wr(8'h99);
        chk(irq === 1'b0, "R11", "write clears", irq, 0);
        @(negedge clk);
        chk(irq === 1'b1, "R10", "empty again after load", irq, 1);
      end
      begin
        logic [7:0] d; logic pb; bit ok;
        rx_frame(8, 0, 1, 16, d, pb, ok);
        chk(ok && d == 8'h99, "R2", "frame after irq", d, 8'h99);
      end
    join
    pulse_isr();
    trig_level = 8'd0;
  endtask

  task automatic t_clear();
    logic [7:0] d; logic pb; bit ok;
    fifo_mode = 1'b1;
    fork
      begin
        burst(8'h5A, 3);
        fifo_clear = 1'b1;
        @(negedge clk); fifo_clear = 1'b0;
        chk(thr_empty === 1'b1 && tx_empty === 1'b0, "R12", "cleared, frame continues",
            {thr_empty, tx_empty}, 2'b10);
      end
      rx_frame(8, 0, 1, 16, d, pb, ok);
    join
    chk(ok && d == 8'h5A, "R12", "frame in flight intact", d, 8'h5A);
    watch_idle(200, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame_8n1();
    t_formats();
    t_bit_time();
    t_single_slot();
    t_queue_full();
    t_irq_stages();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule